// File: doc/BRIEF.md
# Debug System-Speed Access Sequencer

This block steers a processor core that is halted for debugging. Instructions arrive through a 33-bit scan chain: the upper bit is a speed flag and the lower 32 bits are the instruction word. Words with the flag clear run straight away at debug speed. A word that carries the flag must be a memory-transfer instruction. When it is, the block arms itself, and the word sent after it is held back to run at system speed.

The held instruction does not start when it is delivered. It starts when the debugger loads the bypass code into the test-port instruction register. The block then requests the system clock and waits for the clock switch to confirm. It lowers the active-low memory request and waits for a bus grant, with no limit on the wait. On the grant it pulses execute-start. When the pipeline reports execute-done, the block requests the debug clock again. The access is complete once debug acknowledge and memory request are both high. A sticky reason bit then records the round trip. The next capture of the chain returns that bit in the flag position and clears it. If the held instruction is a branch, the core leaves debug state for good and stays on the system clock.

Top module: `dbg_speed_seq`

## Requirements
- R1: A synchronous active-high reset gives `sys_clk_sel`=0, `dbg_ack`=1, `mem_req_n`=1, `exec_start`=0, `insn_out`=0, `status`=4'b0011 and an all-zero chain. Status bits are: [0] debug acknowledge, [1] memory request, [2] illegal-flag error, [3] system-speed reason.
- R2: While `scan_shift` is high, each clock moves `scan_in` into chain bit 32 and shifts the chain one place toward bit 0. `scan_out` always shows chain bit 0.
- R3: An update in the idle condition copies chain bits 31:0 to `insn_out` on the next edge. It also raises `exec_start` for exactly one cycle.
- R4: An idle update with bit 32 set and word bits 27:25 equal to 010, 011 or 100 arms the sequencer. The next update then loads `insn_out` without pulsing `exec_start`.
- R5: An idle update with bit 32 set and any other value in bits 27:25 sets error bit 2, which stays set until reset. The word still runs at debug speed and the sequencer does not arm, so the bypass code has no effect afterwards.
- R6: While the sequencer is armed and holds an instruction, `tap_ir` equal to `BYPASS_CODE` gives `sys_clk_sel`=1 and `dbg_ack`=0 one cycle later. The bypass code is ignored while nothing is held.
- R7: One cycle after `clk_sw_ack` is seen high, `mem_req_n` goes low. It stays low for as long as `bus_grant` stays low.
- R8: `bus_grant` produces a one-cycle `exec_start` on the next edge. `exec_done` then raises `mem_req_n` and clears `sys_clk_sel` on the following edge.
- R9: After `clk_sw_ack` falls, `dbg_ack` goes high on the next edge and reason bit 3 is set. Status bits 0 and 1 are then both high.
- R10: A capture loads chain bit 32 with the reason bit and bits 31:0 with `insn_out`, and it clears the reason bit.
- R11: A held instruction with bits 27:25 equal to 101 (branch) ends in a permanent run state once `clk_sw_ack` is seen. In that state `sys_clk_sel`=1, `dbg_ack`=0 and `mem_req_n`=1, and further updates have no effect.
- R12: Updates while debug acknowledge is low leave `insn_out` and `exec_start` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_in | input | 1 | Serial chain input |
| scan_shift | input | 1 | Shift enable |
| scan_capture | input | 1 | Capture pulse |
| scan_update | input | 1 | Update pulse, delivers the chain word |
| tap_ir | input | IR_W | Current test-port instruction register |
| clk_sw_ack | input | 1 | Clock switch handshake, high when on system clock |
| bus_grant | input | 1 | Memory bus granted |
| exec_done | input | 1 | Pipeline finished the system-speed instruction |
| scan_out | output | 1 | Serial chain output |
| sys_clk_sel | output | 1 | 1 selects system clock |
| dbg_ack | output | 1 | Debug acknowledge |
| mem_req_n | output | 1 | Active-low memory request |
| exec_start | output | 1 | Execute pulse to the pipeline |
| insn_out | output | DATA_W | Instruction word presented to the pipeline |
| status | output | 4 | {reason, error, mem_req_n, dbg_ack} |

## Verification
Every output is a register loaded on the edge that sees its input. Each result is therefore due exactly one cycle after the stimulus is applied: the outputs after an update, bypass, handshake, grant or done, the reason bit after a capture, and the new `scan_out` after a shift. The bench drives inputs at the falling edge. It advances a behavioural model at the rising edge and compares every output at the next falling edge, so each check samples the cycle in which its result is due. Long stalls, ignored inputs and the permanent run state are held for many cycles and compared on every one of them.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ARMED   = 3'd1,
    ST_TO_SYS  = 3'd2,
    ST_SYS_REQ = 3'd3,
    ST_SYS_EXE = 3'd4,
    ST_TO_DBG  = 3'd5,
    ST_RUN     = 3'd6
  } seq_st_t;

  typedef struct packed {
    logic reason;
    logic err;
    logic mreq_n;
    logic ack;
  } seq_stat_t;

  function automatic logic st_has_ack(seq_st_t s);
    return (s == ST_IDLE) || (s == ST_ARMED);
  endfunction

  function automatic logic st_on_sys(seq_st_t s);
    return (s == ST_TO_SYS) || (s == ST_SYS_REQ) || (s == ST_SYS_EXE) || (s == ST_RUN);
  endfunction

  function automatic logic st_mem_busy(seq_st_t s);
    return (s == ST_SYS_REQ) || (s == ST_SYS_EXE);
  endfunction

endpackage

// File: rtl/dbg_insn_class.sv
module dbg_insn_class #(
  parameter int DATA_W  = 32,
  parameter int CLS_LSB = 25
) (
  input  logic [DATA_W-1:0] word,
  output logic              carrier_ok,
  output logic              is_branch
);
  localparam int CLS_MSB = CLS_LSB + 2;

  logic [2:0] cls;

  assign cls = word[CLS_MSB:CLS_LSB];

  always_comb begin
    carrier_ok = 1'b0;
    is_branch  = 1'b0;
    unique case (cls)
      3'b010, 3'b011: carrier_ok = 1'b1;
      3'b100:         carrier_ok = 1'b1;
      3'b101:         is_branch  = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/dbg_scan_chain.sv
module dbg_scan_chain #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              shift_in,
  input  logic              cap_en,
  input  logic              cap_flag,
  input  logic [DATA_W-1:0] cap_word,
  output logic [DATA_W:0]   chain,
  output logic              shift_out
);
  localparam int CHAIN_W = DATA_W + 1;

  logic [CHAIN_W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr <= '0;
    end else if (cap_en) begin
      sr <= {cap_flag, cap_word};
    end else if (shift_en) begin
      sr <= {shift_in, sr[CHAIN_W-1:1]};
    end
  end

  assign chain     = sr;
  assign shift_out = sr[0];
endmodule

// File: rtl/dbg_seq_fsm.sv
module dbg_seq_fsm
  import dbg_seq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  logic              flag,
  input  logic [DATA_W-1:0] word,
  input  logic              carrier_ok,
  input  logic              word_branch,
  input  logic              bypass_sel,
  input  logic              sw_ack,
  input  logic              grant,
  input  logic              done,
  input  logic              capture,
  output seq_st_t           state,
  output logic              sys_sel,
  output logic              ack,
  output logic              mreq_n,
  output logic              start,
  output logic [DATA_W-1:0] insn,
  output logic              reason,
  output logic              err
);
  seq_st_t st_q, st_d;
  logic    held_q, held_d;
  logic    br_q, br_d;
  logic    start_d, err_d, load_d;
  logic    reason_set;

  always_comb begin
    st_d       = st_q;
    held_d     = held_q;
    br_d       = br_q;
    start_d    = 1'b0;
    err_d      = err;
    load_d     = 1'b0;
    reason_set = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (upd) begin
          load_d  = 1'b1;
          start_d = 1'b1;
          if (flag) begin
            if (carrier_ok) begin
              st_d   = ST_ARMED;
              held_d = 1'b0;
            end else begin
              err_d = 1'b1;
            end
          end
        end
      end
      ST_ARMED: begin
        if (held_q && bypass_sel) begin
          st_d = ST_TO_SYS;
        end else if (upd && !held_q) begin
          load_d = 1'b1;
          held_d = 1'b1;
          br_d   = word_branch;
        end
      end
      ST_TO_SYS: begin
        if (sw_ack) st_d = br_q ? ST_RUN : ST_SYS_REQ;
      end
      ST_SYS_REQ: begin
        if (grant) begin
          st_d    = ST_SYS_EXE;
          start_d = 1'b1;
        end
      end
      ST_SYS_EXE: begin
        if (done) st_d = ST_TO_DBG;
      end
      ST_TO_DBG: begin
        if (!sw_ack) begin
          st_d       = ST_IDLE;
          held_d     = 1'b0;
          reason_set = 1'b1;
        end
      end
      ST_RUN: ;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      held_q  <= 1'b0;
      br_q    <= 1'b0;
      sys_sel <= 1'b0;
      ack     <= 1'b1;
      mreq_n  <= 1'b1;
      start   <= 1'b0;
      insn    <= '0;
      reason  <= 1'b0;
      err     <= 1'b0;
    end else begin
      st_q    <= st_d;
      held_q  <= held_d;
      br_q    <= br_d;
      sys_sel <= st_on_sys(st_d);
      ack     <= st_has_ack(st_d);
      mreq_n  <= !st_mem_busy(st_d);
      start   <= start_d;
      err     <= err_d;
      if (load_d) insn <= word;
      if (reason_set)   reason <= 1'b1;
      else if (capture) reason <= 1'b0;
    end
  end

  assign state = st_q;
endmodule

// File: rtl/dbg_speed_seq.sv
module dbg_speed_seq
  import dbg_seq_pkg::*;
#(
  parameter int              DATA_W      = 32,
  parameter int              IR_W        = 4,
  parameter logic [IR_W-1:0] BYPASS_CODE = '1,
  parameter int              CLS_LSB     = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scan_in,
  input  logic              scan_shift,
  input  logic              scan_capture,
  input  logic              scan_update,
  input  logic [IR_W-1:0]   tap_ir,
  input  logic              clk_sw_ack,
  input  logic              bus_grant,
  input  logic              exec_done,
  output logic              scan_out,
  output logic              sys_clk_sel,
  output logic              dbg_ack,
  output logic              mem_req_n,
  output logic              exec_start,
  output logic [DATA_W-1:0] insn_out,
  output logic [3:0]        status
);
  logic [DATA_W:0] chain;
  logic            carrier_ok, word_branch;
  logic            reason, err;
  seq_st_t         state;
  seq_stat_t       stat;

  dbg_scan_chain #(.DATA_W(DATA_W)) u_chain (
    .clk      (clk),
    .rst      (rst),
    .shift_en (scan_shift),
    .shift_in (scan_in),
    .cap_en   (scan_capture),
    .cap_flag (reason),
    .cap_word (insn_out),
    .chain    (chain),
    .shift_out(scan_out)
  );

  dbg_insn_class #(.DATA_W(DATA_W), .CLS_LSB(CLS_LSB)) u_class (
    .word      (chain[DATA_W-1:0]),
    .carrier_ok(carrier_ok),
    .is_branch (word_branch)
  );

  dbg_seq_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .upd        (scan_update),
    .flag       (chain[DATA_W]),
    .word       (chain[DATA_W-1:0]),
    .carrier_ok (carrier_ok),
    .word_branch(word_branch),
    .bypass_sel (tap_ir == BYPASS_CODE),
    .sw_ack     (clk_sw_ack),
    .grant      (bus_grant),
    .done       (exec_done),
    .capture    (scan_capture),
    .state      (state),
    .sys_sel    (sys_clk_sel),
    .ack        (dbg_ack),
    .mreq_n     (mem_req_n),
    .start      (exec_start),
    .insn       (insn_out),
    .reason     (reason),
    .err        (err)
  );

  assign stat.reason = reason;
  assign stat.err    = err;
  assign stat.mreq_n = mem_req_n;
  assign stat.ack    = dbg_ack;
  assign status      = stat;
endmodule

// File: rtl/dbg_speed_seq_chk.sv
module dbg_speed_seq_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              scan_capture,
  input logic              scan_update,
  input logic              sys_clk_sel,
  input logic              dbg_ack,
  input logic              mem_req_n,
  input logic [DATA_W-1:0] insn_out,
  input logic [3:0]        status
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (dbg_ack && mem_req_n && !sys_clk_sel && status == 4'b0011));

  assert_sys_clock_drops_ack_R6: assert property (@(posedge clk) disable iff (rst)
    sys_clk_sel |-> !dbg_ack);

  assert_mem_req_on_sys_R7: assert property (@(posedge clk) disable iff (rst)
    !mem_req_n |-> (sys_clk_sel && !dbg_ack));

  assert_ack_return_done_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(dbg_ack) |-> (mem_req_n && !sys_clk_sel && status[3]));

  assert_capture_clears_reason_R10: assert property (@(posedge clk) disable iff (rst)
    (scan_capture && dbg_ack) |=> !status[3]);

  assert_insn_frozen_R12: assert property (@(posedge clk) disable iff (rst)
    (!dbg_ack && scan_update) |=> $stable(insn_out));
endmodule

bind dbg_speed_seq dbg_speed_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .scan_capture(scan_capture),
  .scan_update (scan_update),
  .sys_clk_sel (sys_clk_sel),
  .dbg_ack     (dbg_ack),
  .mem_req_n   (mem_req_n),
  .insn_out    (insn_out),
  .status      (status)
);

// File: tb/test_dbg_speed_seq.sv
module test_dbg_speed_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] BYP = 4'hF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scan_in = 0, scan_shift = 0, scan_capture = 0, scan_update = 0;
  logic [3:0]  tap_ir = 4'h1;
  logic        clk_sw_ack = 0, bus_grant = 0, exec_done = 0;
  logic        scan_out, sys_clk_sel, dbg_ack, mem_req_n, exec_start;
  logic [31:0] insn_out;
  logic [3:0]  status;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_speed_seq i_dbg_speed_seq (
    .clk(clk), .rst(rst), .scan_in(scan_in), .scan_shift(scan_shift),
    .scan_capture(scan_capture), .scan_update(scan_update), .tap_ir(tap_ir),
    .clk_sw_ack(clk_sw_ack), .bus_grant(bus_grant), .exec_done(exec_done),
    .scan_out(scan_out), .sys_clk_sel(sys_clk_sel), .dbg_ack(dbg_ack),
    .mem_req_n(mem_req_n), .exec_start(exec_start), .insn_out(insn_out),
    .status(status)
  );

  // behavioural reference: mode 0 idle, 1 armed, 2 to-sys, 3 wait grant,
  // 4 executing, 5 to-dbg, 6 running
  int        m_mode;
  bit [32:0] m_ch;
  bit [31:0] m_insn;
  bit        m_held, m_br, m_err, m_rsn, m_start;

  function automatic int cls_of(bit [31:0] w);
    return int'((w >> 25) & 32'd7);
  endfunction

  task automatic model_step();
    bit [32:0] ch = m_ch;
    int cls = cls_of(ch[31:0]);
    m_start = 0;
    if (rst) begin
      m_mode = 0; m_ch = '0; m_insn = '0; m_held = 0; m_br = 0;
      m_err = 0; m_rsn = 0;
      return;
    end
    if (scan_capture) m_ch = {m_rsn, m_insn};
    else if (scan_shift) m_ch = {scan_in, ch[32:1]};
    if (scan_capture) m_rsn = 0;
    case (m_mode)
      0: if (scan_update) begin
           m_insn = ch[31:0]; m_start = 1;
           if (ch[32]) begin
             if (cls == 2 || cls == 3 || cls == 4) begin m_mode = 1; m_held = 0; end
             else m_err = 1;
           end
         end
      1: if (m_held && tap_ir == BYP) m_mode = 2;
         else if (scan_update && !m_held) begin
           m_insn = ch[31:0]; m_held = 1; m_br = (cls == 5);
         end
      2: if (clk_sw_ack) m_mode = m_br ? 6 : 3;
      3: if (bus_grant) begin m_mode = 4; m_start = 1; end
      4: if (exec_done) m_mode = 5;
      5: if (!clk_sw_ack) begin m_mode = 0; m_rsn = 1; m_held = 0; end
      default: ;
    endcase
  endtask

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check("R2 scan_out", scan_out, m_ch[0]);
    check("R6 sys_clk_sel", sys_clk_sel, (m_mode >= 2 && m_mode <= 4) || m_mode == 6);
    check("R9 dbg_ack", dbg_ack, m_mode <= 1);
    check("R7 mem_req_n", mem_req_n, !(m_mode == 3 || m_mode == 4));
    check("R8 exec_start", exec_start, m_start);
    check("R3 insn_out", insn_out, m_insn);
    check("R10 status", status,
          {m_rsn, m_err, !(m_mode == 3 || m_mode == 4), m_mode <= 1});
  endtask

  task automatic load_word(bit flag, bit [31:0] w);
    bit [32:0] v = {flag, w};
    for (int i = 0; i < 33; i++) begin
      scan_shift = 1; scan_in = v[i];
      tick();
    end
    scan_shift = 0; scan_in = 0;
    scan_update = 1; tick(); scan_update = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    rst = 1;
    repeat (3) tick();
    check("R1 status after reset", status, 4'b0011);
    check("R1 insn after reset", insn_out, 32'h0);
    rst = 0;
    tick();

    // R3: plain debug-speed word
    load_word(1'b0, 32'hE1A00000);
    check("R3 pulse on plain update", exec_start, 1'b1);
    tick();
    check("R3 pulse lasts one cycle", exec_start, 1'b0);

    // R5: flagged word of an illegal class
    load_word(1'b1, 32'hE0811002);
    check("R5 error bit set", status[2], 1'b1);
    tap_ir = BYP;
    repeat (3) tick();
    check("R5 bypass ignored, ack high", dbg_ack, 1'b1);
    tap_ir = 4'h1;

    // R4/R6: legal carrier, bypass before any held word is ignored
    load_word(1'b1, 32'hE5901000);
    tap_ir = BYP;
    repeat (2) tick();
    check("R6 bypass ignored with nothing held", sys_clk_sel, 1'b0);
    tap_ir = 4'h1;
    load_word(1'b0, 32'hE8900003);
    check("R4 held word loaded", insn_out, 32'hE8900003);
    check("R4 no pulse for held word", exec_start, 1'b0);
    tap_ir = BYP; tick(); tap_ir = 4'h1;
    check("R6 system clock selected", sys_clk_sel, 1'b1);
    check("R6 ack dropped", dbg_ack, 1'b0);

    // R7: switch acknowledged, bus withheld for a long time
    clk_sw_ack = 1; tick();
    check("R7 request low", mem_req_n, 1'b0);
    scan_update = 1; repeat (2) tick(); scan_update = 0;   // R12 ignored
    repeat (20) tick();
    check("R7 request held through stall", mem_req_n, 1'b0);
    check("R12 insn unchanged", insn_out, 32'hE8900003);

    // R8: grant then done
    bus_grant = 1; tick(); bus_grant = 0;
    check("R8 start on grant", exec_start, 1'b1);
    repeat (4) tick();
    exec_done = 1; tick(); exec_done = 0;
    check("R8 request released", mem_req_n, 1'b1);
    check("R8 clock back to debug", sys_clk_sel, 1'b0);

    // R9: handshake falls
    clk_sw_ack = 0; tick();
    check("R9 ack back", dbg_ack, 1'b1);
    check("R9 completion and reason", status, 4'b1111);

    // R10: capture and shift out
    scan_capture = 1; tick(); scan_capture = 0;
    check("R10 reason cleared", status[3], 1'b0);
    for (int i = 0; i < 33; i++) begin
      check("R10 captured bit", scan_out, (i == 32) ? 1'b1 : 1'(32'hE8900003 >> i));
      scan_shift = 1; tick();
    end
    scan_shift = 0;

    // R11: leave debug state through a branch
    load_word(1'b1, 32'hE5801000);
    load_word(1'b0, 32'hEA000010);
    tap_ir = BYP; tick(); tap_ir = 4'h1;
    clk_sw_ack = 1; tick();
    check("R11 running on system clock", sys_clk_sel, 1'b1);
    check("R11 no memory request", mem_req_n, 1'b1);
    scan_update = 1; repeat (3) tick(); scan_update = 0;
    repeat (8) tick();
    check("R11 ack stays low", dbg_ack, 1'b0);
    check("R12 updates ignored in run", insn_out, 32'hEA000010);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule